// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a clock-synchronous model of the command side of a serial EEPROM. It samples chip select, shift clock and serial data in on the system clock. It finds rising edges of the shift clock and of chip select. It assembles each command from a start bit, a two-bit opcode and an address field, and it answers on a serial data-out line with a separate output enable. The output enable stands for the high-impedance state of a real pin.

The storage is a word array of `DATA_W`-bit words with `ADDR_W` address bits, written so that a block RAM can be inferred. Reads stream words without a break for as long as chip select stays high. Any instruction that changes the array must first be unlocked by a write-enable command. A programming operation runs for a parameterised number of clock cycles. While it runs, a host that deselects and then reselects the block sees ready/busy on data-out.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset `dout_oe` is 0 and the programming lock is closed, so no write takes effect until an enable command is received.
- R2: A command is only recognised after a rising edge of `cs`. Zeros clocked in before the first 1 are skipped. That 1 is the start bit, followed by a 2-bit opcode and then `ADDR_W` address bits, all MSB first and sampled on rising edges of `sk`.
- R3: Opcode 10 reads. Once the last address bit is captured, `dout_oe` goes to 1 and `dout` shows a single 0. After that, each rising edge of `sk` presents the next data bit, MSB first. `dout` changes at no other time during the read.
- R4: While `cs` stays high, the read continues with the following address, wrapping from the top address to 0, with no extra 0 between words.
- R5: Opcode 00 is a control group selected by the top two address bits: 11 opens the programming lock and 00 closes it. With the lock closed, write, erase, erase-all and write-all leave the array unchanged. Reads work with the lock open or closed.
- R6: Opcode 01 followed by `DATA_W` data bits stores the data at the address, replacing any earlier contents without a prior erase.
- R7: Opcode 11 sets every bit of the addressed word to 1.
- R8: Control sub-code 10 sets every word to all ones. Control sub-code 01, followed by `DATA_W` data bits, stores that data in every word.
- R9: A programming operation starts when its command is complete. It stays busy for at least `PROG_CYCLES` clocks, and at least one clock per word for the whole-array operations. If `cs` falls and then rises during that time, `dout_oe` is 1 and `dout` shows 0 while busy and 1 once ready.
- R10: If `cs` rises only after programming has finished, no status is driven and `dout_oe` stays 0.
- R11: Any command sent while programming is busy is ignored.
- R12: `dout_oe` is 0 one clock after `cs` is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial shift clock, sampled on `clk` |
| di | input | 1 | Serial data in |
| dout | output | 1 | Serial data out (read data or ready/busy) |
| dout_oe | output | 1 | Output enable for `dout`; 0 means high impedance |

## Verification
The bench builds the block with `ADDR_W` = 4, `DATA_W` = 16 and `PROG_CYCLES` = 300. The 16-word array lets a single sequential read cover every word after erase-all and write-all, and exercise the wrap from address 15 to 0. A 300-clock busy window is longer than a whole command frame, so a second command can be sent while programming is still running. The bench can also deselect for longer than that window and confirm that no status appears afterwards.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [2:0] {
    ST_OFF,   // deselected or waiting for a chip-select rising edge
    ST_WAIT,  // hunting for the start bit
    ST_OPC,   // shifting the two opcode bits
    ST_ADDR,  // shifting the address field
    ST_DATA,  // shifting write data
    ST_READ,  // streaming words out
    ST_STAT,  // driving ready/busy
    ST_PARK   // command finished or ignored, wait for deselect
  } fsm_t;

  localparam logic [1:0] OPC_CTRL  = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] SUB_LOCK    = 2'b00;
  localparam logic [1:0] SUB_FILL    = 2'b01;
  localparam logic [1:0] SUB_WIPE    = 2'b10;
  localparam logic [1:0] SUB_UNLOCK  = 2'b11;
endpackage

// File: rtl/ee_pin_sampler.sv
module ee_pin_sampler (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sk,
  output logic sk_rise,
  output logic cs_rise
);
  logic sk_q;
  logic cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sk_q <= 1'b0;
      cs_q <= 1'b1;
    end else begin
      sk_q <= sk;
      cs_q <= cs;
    end
  end

  assign sk_rise = sk & ~sk_q;
  assign cs_rise = cs & ~cs_q;
endmodule

// File: rtl/ee_word_ram.sv
module ee_word_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ee_prog_seq.sv
module ee_prog_seq #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 20000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              bulk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic [CNT_W-1:0]  cnt;
  logic              sweep;
  logic              pend;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] paddr;
  logic [DATA_W-1:0] pdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      sweep <= 1'b0;
      pend  <= 1'b0;
      ptr   <= '0;
      paddr <= '0;
      pdata <= '0;
    end else if (go) begin
      busy  <= 1'b1;
      cnt   <= CNT_W'(PROG_CYCLES - 1);
      sweep <= bulk;
      pend  <= ~bulk;
      ptr   <= '0;
      paddr <= addr;
      pdata <= data;
    end else if (busy) begin
      pend <= 1'b0;
      if (sweep) begin
        ptr <= ptr + 1'b1;
        if (&ptr) sweep <= 1'b0;
      end
      if (cnt != '0) cnt <= cnt - 1'b1;
      if (cnt == '0 && !sweep && !pend) busy <= 1'b0;
    end
  end

  assign wr_en   = pend | sweep;
  assign wr_addr = sweep ? ptr : paddr;
  assign wr_data = pdata;

  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst) go |-> !busy); // R11
  AST_SWEEP_INSIDE_BUSY: assert property (@(posedge clk) disable iff (rst) sweep |-> busy); // R8
  AST_BUSY_HOLDS_AFTER_GO: assert property (@(posedge clk) disable iff (rst) go |=> busy); // R9
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 20000
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout,
  output logic dout_oe
);
  import ee_pkg::*;

  localparam int LEN_MAX = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int LEN_W   = $clog2(LEN_MAX);
  localparam int BIT_W   = $clog2(DATA_W);

  logic sk_rise, cs_rise;
  logic busy;
  logic wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rdata;

  fsm_t              st;
  logic [1:0]        opc;
  logic [ADDR_W-1:0] areg;
  logic [DATA_W-1:0] dreg;
  logic [LEN_W-1:0]  len;
  logic              wen;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rsh;
  logic [BIT_W-1:0]  rbit;
  logic              go;
  logic              go_bulk;
  logic [ADDR_W-1:0] go_addr;
  logic [DATA_W-1:0] go_data;

  logic [ADDR_W-1:0] a_next;
  logic [DATA_W-1:0] d_next;
  logic [1:0]        sub;

  assign a_next = {areg[ADDR_W-2:0], di};
  assign d_next = {dreg[DATA_W-2:0], di};
  assign sub    = a_next[ADDR_W-1 -: 2];

  ee_pin_sampler u_pins (
    .clk(clk), .rst(rst), .cs(cs), .sk(sk),
    .sk_rise(sk_rise), .cs_rise(cs_rise)
  );

  ee_word_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rdata)
  );

  ee_prog_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst(rst), .go(go), .bulk(go_bulk), .addr(go_addr), .data(go_data),
    .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_OFF;
      opc     <= '0;
      areg    <= '0;
      dreg    <= '0;
      len     <= '0;
      wen     <= 1'b0;
      rd_addr <= '0;
      rsh     <= '0;
      rbit    <= '0;
      go      <= 1'b0;
      go_bulk <= 1'b0;
      go_addr <= '0;
      go_data <= '0;
      dout    <= 1'b0;
      dout_oe <= 1'b0;
    end else begin
      go <= 1'b0;
      if (!cs) begin
        st      <= ST_OFF;
        dout_oe <= 1'b0;
      end else if (cs_rise) begin
        st      <= busy ? ST_STAT : ST_WAIT;
        dout_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_WAIT: begin
            if (sk_rise && di) begin
              st  <= ST_OPC;
              len <= LEN_W'(1);
            end
          end
          ST_OPC: begin
            if (sk_rise) begin
              opc <= {opc[0], di};
              if (len == '0) begin
                st  <= ST_ADDR;
                len <= LEN_W'(ADDR_W - 1);
              end else begin
                len <= len - 1'b1;
              end
            end
          end
          ST_ADDR: begin
            if (sk_rise) begin
              areg <= a_next;
              if (len != '0) begin
                len <= len - 1'b1;
              end else begin
                st <= ST_PARK;
                unique case (opc)
                  OPC_READ: begin
                    st      <= ST_READ;
                    rd_addr <= a_next;
                    rbit    <= '0;
                    dout    <= 1'b0;
                    dout_oe <= 1'b1;
                  end
                  OPC_WRITE: begin
                    if (wen) begin
                      st  <= ST_DATA;
                      len <= LEN_W'(DATA_W - 1);
                    end
                  end
                  OPC_ERASE: begin
                    if (wen) begin
                      go      <= 1'b1;
                      go_bulk <= 1'b0;
                      go_addr <= a_next;
                      go_data <= '1;
                    end
                  end
                  default: begin
                    unique case (sub)
                      SUB_UNLOCK: wen <= 1'b1;
                      SUB_LOCK:   wen <= 1'b0;
                      SUB_WIPE: begin
                        if (wen) begin
                          go      <= 1'b1;
                          go_bulk <= 1'b1;
                          go_addr <= '0;
                          go_data <= '1;
                        end
                      end
                      default: begin
                        if (wen) begin
                          st  <= ST_DATA;
                          len <= LEN_W'(DATA_W - 1);
                        end
                      end
                    endcase
                  end
                endcase
              end
            end
          end
          ST_DATA: begin
            if (sk_rise) begin
              dreg <= d_next;
              if (len != '0) begin
                len <= len - 1'b1;
              end else begin
                st      <= ST_PARK;
                go      <= 1'b1;
                go_bulk <= (opc == OPC_CTRL);
                go_addr <= areg;
                go_data <= d_next;
              end
            end
          end
          ST_READ: begin
            if (sk_rise) begin
              if (rbit == '0) begin
                dout    <= rdata[DATA_W-1];
                rsh     <= {rdata[DATA_W-2:0], 1'b0};
                rbit    <= BIT_W'(DATA_W - 1);
                rd_addr <= rd_addr + 1'b1;
              end else begin
                dout <= rsh[DATA_W-1];
                rsh  <= {rsh[DATA_W-2:0], 1'b0};
                rbit <= rbit - 1'b1;
              end
            end
          end
          ST_STAT: begin
            dout_oe <= 1'b1;
            dout    <= ~busy;
          end
          default: ;
        endcase
      end
    end
  end

  AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (rst) !cs |=> !dout_oe); // R12
  AST_PROG_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (rst) go |-> wen); // R5
  AST_READ_ON_SK_ONLY: assert property (@(posedge clk) disable iff (rst)
    (st == ST_READ && $past(st) == ST_READ && !$past(sk_rise)) |-> $stable(dout)); // R3
  AST_STATUS_IS_READY_FLAG: assert property (@(posedge clk) disable iff (rst)
    (st == ST_STAT && $past(st) == ST_STAT && $past(cs)) |-> (dout_oe && dout == !$past(busy))); // R9
endmodule

// File: tb/tb_serial_eeprom_slave.sv
module tb_serial_eeprom_slave;
  localparam int AW    = 4;
  localparam int DW    = 16;
  localparam int PROG  = 300;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic dout, dout_oe;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [DW-1:0] mm [DEPTH];
  bit wen_m = 1'b0;

  logic [DW-1:0] exp_q [$];
  logic [DW-1:0] got_q [$];
  string         tag_q [$];

  always #2 clk = ~clk;

  serial_eeprom_slave #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        logic [DW-1:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(g === e, t, g, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_in(input bit b);
    di = b; tick(2); sk = 1'b1; tick(3); sk = 1'b0; tick(1);
  endtask

  task automatic shift_out(output bit b);
    sk = 1'b1; tick(3); b = dout; sk = 1'b0; tick(2);
  endtask

  task automatic frame(input logic [1:0] op, input logic [AW-1:0] a, input int zeros);
    cs = 1'b0; tick(2); cs = 1'b1; tick(2);
    for (int i = 0; i < zeros; i++) shift_in(1'b0);
    shift_in(1'b1);
    shift_in(op[1]); shift_in(op[0]);
    for (int i = AW - 1; i >= 0; i--) shift_in(a[i]);
  endtask

  task automatic send_data(input logic [DW-1:0] d);
    for (int i = DW - 1; i >= 0; i--) shift_in(d[i]);
  endtask

  task automatic deselect();
    cs = 1'b0; tick(2);
  endtask

  task automatic wait_ready(input string req);
    bit seen = 1'b0;
    cs = 1'b0; tick(2); cs = 1'b1; tick(3);
    check(dout_oe === 1'b1 && dout === 1'b0, req, {14'd0, dout_oe, dout}, 16'h2);
    for (int i = 0; i < PROG + DEPTH + 60; i++) begin
      if (dout === 1'b1) begin seen = 1'b1; break; end
      tick(1);
    end
    check(seen && dout_oe === 1'b1, req, {15'd0, seen}, 16'h1);
    deselect();
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    frame(2'b01, a, 0); send_data(d); deselect();
    if (wen_m) begin mm[a] = d; wait_ready("R9 write status"); end
  endtask

  task automatic do_ctrl(input logic [1:0] sub);
    frame(2'b00, {sub, {(AW-2){1'b0}}}, 0); deselect();
    if (sub == 2'b11) wen_m = 1'b1;
    if (sub == 2'b00) wen_m = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int n, input int zeros, input string req);
    bit b;
    logic [DW-1:0] w;
    frame(2'b10, a, zeros);
    check(dout_oe === 1'b1 && dout === 1'b0, "R3 dummy zero", {14'd0, dout_oe, dout}, 16'h2);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(mm[(int'(a) + k) % DEPTH]);
      tag_q.push_back(req);
      w = '0;
      for (int i = 0; i < DW; i++) begin shift_out(b); w = {w[DW-2:0], b}; end
      got_q.push_back(w);
    end
    deselect();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(4); rst = 1'b0; tick(2);
    check(dout_oe === 1'b0, "R1 reset oe", {15'd0, dout_oe}, 16'h0);

    // R1/R5: write while locked -> no programming, so no status afterwards
    frame(2'b01, 4'd3, 0); send_data(16'h1234); deselect();
    cs = 1'b1; tick(4);
    check(dout_oe === 1'b0, "R1 locked write not started", {15'd0, dout_oe}, 16'h0);
    deselect();

    do_ctrl(2'b11);
    // R8 erase-all
    frame(2'b00, {2'b10, {(AW-2){1'b0}}}, 0); deselect();
    for (int i = 0; i < DEPTH; i++) mm[i] = '1;
    wait_ready("R9 erase-all status");
    do_read(4'd0, DEPTH, 0, "R8 erase-all word");

    // R6 write, R3 read with R2 leading zeros
    do_write(4'd3, 16'h1234);
    do_write(4'd4, 16'hA5C3);
    do_read(4'd3, 2, 3, "R2 R6 written word");
    do_write(4'd3, 16'h00FF);
    do_read(4'd3, 1, 0, "R6 overwrite without erase");

    // R7 erase one word
    frame(2'b11, 4'd4, 0); deselect();
    mm[4] = '1;
    wait_ready("R9 erase status");
    do_read(4'd4, 1, 0, "R7 erased word");

    // R8 write-all, R4 wrap read
    frame(2'b00, {2'b01, {(AW-2){1'b0}}}, 0); send_data(16'h5A0F); deselect();
    for (int i = 0; i < DEPTH; i++) mm[i] = 16'h5A0F;
    wait_ready("R9 write-all status");
    do_read(4'd14, 4, 0, "R4 R8 wrap read");

    // R11 command during busy ignored
    frame(2'b01, 4'd5, 0); send_data(16'h1111); deselect();
    mm[5] = 16'h1111;
    frame(2'b01, 4'd6, 0); send_data(16'h2222); deselect();
    wait_ready("R11 status after ignored cmd");
    do_read(4'd5, 2, 0, "R11 ignored while busy");

    // R10 no status after completion
    frame(2'b01, 4'd8, 0); send_data(16'hC0DE); deselect();
    mm[8] = 16'hC0DE;
    tick(PROG + DEPTH + 40);
    cs = 1'b1; tick(4);
    check(dout_oe === 1'b0, "R10 no late status", {15'd0, dout_oe}, 16'h0);
    deselect();
    do_read(4'd8, 1, 0, "R10 write landed");

    // R5 lock again: write ignored, read still works
    do_ctrl(2'b00);
    do_write(4'd7, 16'hBEEF);
    do_read(4'd7, 1, 0, "R5 locked write ignored");

    // R12 deselect mid-read
    begin
      bit b;
      frame(2'b10, 4'd0, 0);
      for (int i = 0; i < 5; i++) shift_out(b);
      cs = 1'b0; tick(1);
      check(dout_oe === 1'b0, "R12 oe off after deselect", {15'd0, dout_oe}, 16'h0);
      tick(2);
    end

    tick(10);
    check(exp_q.size() == 0 && got_q.size() == 0, "R3 scoreboard drained",
          DW'(exp_q.size()), 16'h0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule